// File: doc/BRIEF.md
# I2C Target with Auto-Incrementing Register Bank

This block lets an external I2C master read and write a bank of 8-bit registers held inside the chip. It runs entirely on a fast system clock and oversamples the SCL and SDA lines through synchronizers. It recognises START, repeated START and STOP conditions and matches a 7-bit device address. It keeps one 8-bit register pointer that advances on every byte moved. The block never drives SDA high. It only asserts an enable that pulls the open-drain line low.

A write frame carries the device address with the direction bit clear, then one byte that sets the pointer, then any number of data bytes. Each data byte lands at the pointer and then moves the pointer on. A read frame that begins with a plain START restarts from register 0x00. A read that follows a repeated START, after a pointer byte in the same frame, continues from the preset pointer. Pointer values from 0xE8 upward are reserved. Writes to them are acknowledged and dropped, and reads from them return zero. The whole bank is always visible on a flat parallel output, so the rest of the chip can use the settings directly.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, sdaOe is low and every register in the bank reads 0x00 on the parallel output.
- R2: An address byte whose upper 7 bits equal DEV_ADDR is acknowledged by holding SDA low through the 9th SCL pulse. Bit 0 of that byte selects the direction, 0 for write and 1 for read.
- R3: An address byte that does not match gets no acknowledge. Every later bit is ignored, with no acknowledge and no register change, until the next START or STOP.
- R4: In a write frame, the first byte after the address loads the pointer. Each following byte is stored at the pointer, acknowledged, and then the pointer advances by one. Register k appears on regBank[8k+7:8k].
- R5: A read that follows a plain START returns register 0x00 first, then consecutive registers.
- R6: A read that follows a repeated START, after a pointer byte in the same frame, returns the register at the preset pointer first.
- R7: Each byte sent in a read advances the pointer by one. A later repeated START read in the same frame continues from where the last read stopped.
- R8: When the master answers a read byte with NACK (SDA high), the block releases SDA. It drives nothing on further SCL pulses until a START or STOP.
- R9: Pointer values from 0xE8 to 0xFF are reserved. Writes there are acknowledged but change no register, and reads there return 0x00.
- R10: The pointer is 8 bits wide and wraps from 0xFF to 0x00 on both reads and writes.
- R11: sdaOe changes only while SCL is low, after a falling SCL edge, so read data and acknowledges hold steady while SCL is high.
- R12: A STOP at any point returns the block to idle with SDA released, and the next frame is handled normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line level from the pad |
| sdaIn | input | 1 | SDA line level from the pad |
| sdaOe | output | 1 | When high, the pad pulls SDA low |
| regBank | output | NUM_REGS*8 | All registers, register k at bits 8k+7 down to 8k |

## Verification
A data byte's store and the pointer advance happen on the same system clock edge. So the store must use the pointer value from before that edge, including when the pointer steps from 0xE7 into the reserved range or wraps from 0xFF to 0x00. Write bursts that start at 0xE6 and at 0xFE cross exactly those boundaries. They are judged on the parallel output against a bench model that drops reserved writes and wraps the pointer. Reads at the same boundaries then confirm the pointer path on its own. A second clash is a repeated START that comes right after a NACK or an address mismatch. The bench checks that the pointer carries over rather than being cleared.

// File: rtl/i2c_reg_pkg.sv
`timescale 1ns/1ps
package i2c_reg_pkg;

  localparam int PTR_W = 8;

  // Events seen on the synchronized bus, one system clock wide each
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaLvl;
  } busEvT;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic ptrLoad;
    logic ptrClear;
    logic wrCommit;
    logic txLoad;
    logic txShift;
  } dpCtlT;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RMACK,
    ST_IGNORE
  } ctlStateT;

endpackage

// File: rtl/i2c_bus_sync.sv
`timescale 1ns/1ps
module i2c_bus_sync
  import i2c_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  sclIn,
  input  logic  sdaIn,
  output busEvT busEv,
  output logic  sclLvl
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclPipe;
  logic [TOP:0] sdaPipe;
  logic         sclPrev;
  logic         sdaPrev;
  logic         sclS;
  logic         sdaS;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[TOP-1:0], sclIn};
          sdaPipe <= {sdaPipe[TOP-1:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclPipe[TOP];
  assign sdaS = sdaPipe[TOP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  always_comb begin
    busEv.sclRise   = sclS & ~sclPrev;
    busEv.sclFall   = ~sclS & sclPrev;
    busEv.startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
    busEv.stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;
    busEv.sdaLvl    = sdaS;
  end

  assign sclLvl = sclS;

endmodule

// File: rtl/i2c_reg_ctl.sv
`timescale 1ns/1ps
module i2c_reg_ctl
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1A
) (
  input  logic       clk,
  input  logic       rstN,
  input  busEvT      busEv,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpCtlT      dpCtl,
  output logic       sdaOe
);

  localparam logic [3:0] LAST_RX = 4'd8;
  localparam logic [3:0] LAST_TX = 4'd7;

  ctlStateT   state, stateNxt;
  logic [3:0] bitCnt, cntNxt;
  logic       rwFlag, rwNxt;
  logic       inFrame, frameNxt;
  logic       ptrPreset, presetNxt;
  logic       masterAck, mackNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      rwFlag    <= 1'b0;
      inFrame   <= 1'b0;
      ptrPreset <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateNxt;
      bitCnt    <= cntNxt;
      rwFlag    <= rwNxt;
      inFrame   <= frameNxt;
      ptrPreset <= presetNxt;
      masterAck <= mackNxt;
    end
  end

  always_comb begin
    stateNxt  = state;
    cntNxt    = bitCnt;
    rwNxt     = rwFlag;
    frameNxt  = inFrame;
    presetNxt = ptrPreset;
    mackNxt   = masterAck;
    dpCtl     = '0;

    if (busEv.stopSeen) begin
      stateNxt  = ST_IDLE;
      frameNxt  = 1'b0;
      presetNxt = 1'b0;
    end else if (busEv.startSeen) begin
      stateNxt = ST_ADDR;
      cntNxt   = '0;
      if (!inFrame) presetNxt = 1'b0;
      frameNxt = 1'b1;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (busEv.sclRise && bitCnt != LAST_RX) begin
            dpCtl.shiftIn = 1'b1;
            cntNxt        = bitCnt + 4'd1;
          end else if (busEv.sclFall && bitCnt == LAST_RX) begin
            cntNxt = '0;
            case (state)
              ST_ADDR: begin
                if (rxByte[7:1] == DEV_ADDR) begin
                  stateNxt = ST_ADDR_ACK;
                  rwNxt    = rxByte[0];
                  if (rxByte[0] && !ptrPreset) dpCtl.ptrClear = 1'b1;
                end else begin
                  stateNxt = ST_IGNORE;
                end
              end
              ST_PTR: begin
                dpCtl.ptrLoad = 1'b1;
                presetNxt     = 1'b1;
                stateNxt      = ST_PTR_ACK;
              end
              default: begin
                dpCtl.wrCommit = 1'b1;
                stateNxt       = ST_WDATA_ACK;
              end
            endcase
          end
        end
        ST_ADDR_ACK: begin
          if (busEv.sclFall) begin
            if (rwFlag) begin
              dpCtl.txLoad = 1'b1;
              stateNxt     = ST_RDATA;
            end else begin
              stateNxt = ST_PTR;
            end
          end
        end
        ST_PTR_ACK, ST_WDATA_ACK: begin
          if (busEv.sclFall) stateNxt = ST_WDATA;
        end
        ST_RDATA: begin
          if (busEv.sclFall) begin
            if (bitCnt == LAST_TX) begin
              cntNxt   = '0;
              stateNxt = ST_RMACK;
            end else begin
              dpCtl.txShift = 1'b1;
              cntNxt        = bitCnt + 4'd1;
            end
          end
        end
        ST_RMACK: begin
          if (busEv.sclRise) begin
            mackNxt = ~busEv.sdaLvl;
          end else if (busEv.sclFall) begin
            if (masterAck) begin
              dpCtl.txLoad = 1'b1;
              stateNxt     = ST_RDATA;
            end else begin
              stateNxt = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // Pull low during any acknowledge slot, or for a zero read bit
  assign sdaOe = (state == ST_ADDR_ACK) || (state == ST_PTR_ACK) ||
                 (state == ST_WDATA_ACK) || (state == ST_RDATA && !txBit);

endmodule

// File: rtl/i2c_reg_dp.sv
`timescale 1ns/1ps
module i2c_reg_dp
  import i2c_reg_pkg::*;
#(
  parameter int NUM_REGS = 232
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtlT                 dpCtl,
  input  logic                  sdaLvl,
  output logic [7:0]            rxByte,
  output logic                  txBit,
  output logic [PTR_W-1:0]      ptr,
  output logic [NUM_REGS*8-1:0] regBank
);

  localparam int BANK_W = NUM_REGS * 8;

  logic [7:0]      rxShift;
  logic [7:0]      txShift;
  logic [7:0]      rdByte;
  logic [BANK_W-1:0] bankQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (dpCtl.shiftIn) begin
      rxShift <= {rxShift[6:0], sdaLvl};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (dpCtl.ptrClear) begin
      ptr <= '0;
    end else if (dpCtl.ptrLoad) begin
      ptr <= rxShift;
    end else if (dpCtl.wrCommit || dpCtl.txLoad) begin
      ptr <= ptr + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= 8'hFF;
    end else if (dpCtl.txLoad) begin
      txShift <= rdByte;
    end else if (dpCtl.txShift) begin
      txShift <= {txShift[6:0], 1'b1};
    end
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [7:0] regQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          regQ <= '0;
        end else if (dpCtl.wrCommit && ptr == 8'(g)) begin
          regQ <= rxShift;
        end
      end
      assign bankQ[g*8 +: 8] = regQ;
    end
  endgenerate

  // Reserved pointer values match no register and read as zero
  always_comb begin
    rdByte = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ptr == 8'(i)) rdByte = bankQ[i*8 +: 8];
    end
  end

  assign rxByte  = rxShift;
  assign txBit   = txShift[7];
  assign regBank = bankQ;

endmodule

// File: rtl/i2c_reg_target.sv
`timescale 1ns/1ps
module i2c_reg_target
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h1A,
  parameter int         NUM_REGS    = 232,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] regBank
);

  busEvT            busEv;
  dpCtlT            dpCtl;
  logic             sclLvl;
  logic [7:0]       rxByte;
  logic             txBit;
  logic [PTR_W-1:0] ptr;

  i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .busEv  (busEv),
    .sclLvl (sclLvl)
  );

  i2c_reg_ctl #(.DEV_ADDR(DEV_ADDR)) u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .busEv  (busEv),
    .rxByte (rxByte),
    .txBit  (txBit),
    .dpCtl  (dpCtl),
    .sdaOe  (sdaOe)
  );

  i2c_reg_dp #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtl   (dpCtl),
    .sdaLvl  (busEv.sdaLvl),
    .rxByte  (rxByte),
    .txBit   (txBit),
    .ptr     (ptr),
    .regBank (regBank)
  );

endmodule

// File: rtl/i2c_reg_target_chk.sv
`timescale 1ns/1ps
module i2c_reg_target_chk #(
  parameter int NUM_REGS = 232
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sdaOe,
  input logic [NUM_REGS*8-1:0] regBank,
  input logic                  sclLvl,
  input logic                  stopSeen,
  input logic                  wrCommit,
  input logic                  ptrClear,
  input logic [7:0]            ptr,
  input logic [7:0]            rxByte
);

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclLvl); // R11

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaOe); // R12

  AST_RESERVED_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (wrCommit && ptr >= NUM_REGS) |=> $stable(regBank)); // R9

  AST_WRITE_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |=> ptr == 8'($past(ptr) + 8'd1)); // R10

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (wrCommit && ptr < NUM_REGS) |=> regBank[$past(ptr)*8 +: 8] == $past(rxByte)); // R4

  AST_PLAIN_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ptrClear |=> ptr == 8'd0); // R5

endmodule

bind i2c_reg_target i2c_reg_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sdaOe    (sdaOe),
  .regBank  (regBank),
  .sclLvl   (sclLvl),
  .stopSeen (busEv.stopSeen),
  .wrCommit (dpCtl.wrCommit),
  .ptrClear (dpCtl.ptrClear),
  .ptr      (ptr),
  .rxByte   (rxByte)
);

// File: tb/i2c_reg_target_bench.sv
`timescale 1ns/1ps
module i2c_reg_target_bench;

  localparam int         NREG = 232;
  localparam logic [6:0] DEV  = 7'h1A;
  localparam int         Q    = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic sdaBus;
  logic [NREG*8-1:0] regBank;

  int checks = 0;
  int errors = 0;
  int stableErr = 0;
  bit finished = 1'b0;
  logic [7:0] model [256];
  logic [7:0] wbuf [16];

  always #5 clk = ~clk;

  assign sdaBus = sdaM & ~sdaOe;

  i2c_reg_target #(.DEV_ADDR(DEV), .NUM_REGS(NREG)) u_i2c_reg_target (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclM),
    .sdaIn   (sdaBus),
    .sdaOe   (sdaOe),
    .regBank (regBank)
  );

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bankDiff();
    int n = 0;
    for (int k = 0; k < NREG; k++)
      if (regBank[k*8 +: 8] !== model[k]) n++;
    return n;
  endfunction

  function automatic logic [7:0] expRead(input logic [7:0] p);
    return (p < NREG) ? model[p] : 8'h00;
  endfunction

  task automatic busStart();
    sdaM = 1'b1; qw(); sclM = 1'b1; qw(); sdaM = 1'b0; qw(); sclM = 1'b0; qw();
  endtask

  task automatic busStop();
    sdaM = 1'b0; qw(); sclM = 1'b1; qw(); sdaM = 1'b1; qw();
  endtask

  task automatic putBit(input logic b);
    sdaM = b; qw(); sclM = 1'b1; qw(); qw(); sclM = 1'b0; qw();
  endtask

  task automatic getBit(output logic b);
    logic b2;
    sdaM = 1'b1; qw(); sclM = 1'b1; qw();
    b = sdaBus; qw(); b2 = sdaBus;
    if (b2 !== b) stableErr++;
    sclM = 1'b0; qw();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    ack = ~b;
  endtask

  task automatic recvByte(output logic [7:0] v, input logic ackIt);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      v[i] = b;
    end
    putBit(~ackIt);
  endtask

  task automatic wrFrame(input logic [7:0] p, input int n, input string req);
    logic a;
    logic [7:0] mp;
    busStart();
    sendByte({DEV, 1'b0}, a); checkEq("R2 write address ack", a, 1);
    sendByte(p, a);           checkEq("R4 pointer byte ack", a, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(wbuf[i], a);
      checkEq({req, " data ack"}, a, 1);
    end
    busStop();
    mp = p;
    for (int i = 0; i < n; i++) begin
      if (mp < NREG) model[mp] = wbuf[i];
      mp = mp + 8'd1;
    end
    checkEq({req, " bank contents"}, bankDiff(), 0);
  endtask

  task automatic rdPreset(input logic [7:0] p, input int n, input string req);
    logic a;
    logic [7:0] v;
    busStart();
    sendByte({DEV, 1'b0}, a); checkEq("R2 address ack", a, 1);
    sendByte(p, a);           checkEq("R4 pointer ack", a, 1);
    busStart();
    sendByte({DEV, 1'b1}, a); checkEq("R2 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(v, i != n - 1);
      checkEq(req, v, expRead(8'(p + 8'(i))));
    end
    busStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    logic b;
    logic [7:0] v;
    int ones;
    void'($urandom(32'd2024));
    for (int k = 0; k < 256; k++) model[k] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    checkEq("R1 sdaOe after reset", sdaOe, 0);
    checkEq("R1 bank after reset", bankDiff(), 0);

    // R4 directed burst at register 0
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'hC3;
    wrFrame(8'h00, 3, "R4 burst at 0");

    // R4/R6 random bursts read back through a repeated START
    for (int it = 0; it < 10; it++) begin
      logic [7:0] p;
      int n;
      p = 8'($urandom_range(0, NREG - 1));
      n = $urandom_range(1, 6);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wrFrame(p, n, "R4 random burst");
      rdPreset(p, n, "R6 preset read data");
    end

    // R5 plain START read restarts at 0x00 even after a preset
    busStart();
    sendByte({DEV, 1'b1}, a); checkEq("R5 read address ack", a, 1);
    for (int i = 0; i < 4; i++) begin
      recvByte(v, i != 3);
      checkEq("R5 plain read data", v, expRead(8'(i)));
    end
    busStop();

    // R9 burst across the reserved boundary
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wrFrame(8'hE6, 4, "R9 reserved burst");
    rdPreset(8'hE6, 4, "R9 reserved read data");

    // R10 pointer wrap on write and read
    wbuf[0] = 8'h66; wbuf[1] = 8'h77; wbuf[2] = 8'h88; wbuf[3] = 8'h99;
    wrFrame(8'hFE, 4, "R10 wrap burst");
    rdPreset(8'hFF, 3, "R10 wrap read data");

    // R3 mismatched address: no ack, nothing stored
    busStart();
    sendByte({DEV ^ 7'h01, 1'b0}, a); checkEq("R3 mismatch address ack", a, 0);
    sendByte(8'h20, a);               checkEq("R3 ignored byte ack", a, 0);
    sendByte(8'h77, a);               checkEq("R3 ignored byte ack", a, 0);
    checkEq("R3 bank unchanged", bankDiff(), 0);
    // repeated START with the right address recovers
    wbuf[0] = 8'h3C;
    busStart();
    sendByte({DEV, 1'b0}, a); checkEq("R3 recover address ack", a, 1);
    sendByte(8'h20, a);       checkEq("R3 recover pointer ack", a, 1);
    sendByte(wbuf[0], a);     checkEq("R3 recover data ack", a, 1);
    busStop();
    model[8'h20] = wbuf[0];
    checkEq("R3 recover bank", bankDiff(), 0);

    // R8 NACK releases the bus; R7 pointer carries to next repeated START
    busStart();
    sendByte({DEV, 1'b0}, a); checkEq("R2 address ack", a, 1);
    sendByte(8'h10, a);       checkEq("R4 pointer ack", a, 1);
    busStart();
    sendByte({DEV, 1'b1}, a); checkEq("R2 read address ack", a, 1);
    recvByte(v, 1'b1); checkEq("R7 first byte", v, expRead(8'h10));
    recvByte(v, 1'b0); checkEq("R7 second byte", v, expRead(8'h11));
    ones = 0;
    for (int i = 0; i < 9; i++) begin
      getBit(b);
      if (b) ones++;
    end
    checkEq("R8 bus released after NACK", ones, 9);
    busStart();
    sendByte({DEV, 1'b1}, a); checkEq("R7 reread address ack", a, 1);
    recvByte(v, 1'b0); checkEq("R7 pointer continued", v, expRead(8'h12));
    busStop();

    // R12 STOP in the middle of a data byte
    busStart();
    sendByte({DEV, 1'b0}, a); checkEq("R2 address ack", a, 1);
    sendByte(8'h30, a);       checkEq("R4 pointer ack", a, 1);
    putBit(1'b1); putBit(1'b0); putBit(1'b1); putBit(1'b1);
    busStop();
    checkEq("R12 sdaOe idle after stop", sdaOe, 0);
    checkEq("R12 partial byte not stored", bankDiff(), 0);
    wbuf[0] = 8'hE1;
    wrFrame(8'h30, 1, "R12 frame after stop");

    checkEq("R11 read data stable while SCL high", stableErr, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule